// File: doc/BRIEF.md
# Merging Store Buffer

This block is a short queue placed between a write-through cache and the next memory level. Processor stores land here and complete at once. The queue then empties itself toward memory in the background. Each slot covers one aligned block of four words. A slot stores the block address, the data of every word and a bit per word that marks which words have been written.

When a cacheable store targets a block that already owns a slot, and that slot is not currently being sent, the store is folded into the slot instead of using a new one. This keeps the queue from filling up during bursts of nearby stores. Stores whose address falls in the uncached I/O window never fold. Each one takes its own slot and becomes its own memory write.

Draining is controlled by a two-state machine. In `DR_IDLE` the queue waits. The transition *start* (queue not empty) moves it to `DR_SEND`, where the oldest slot is presented and locked against folding. The transition *next* (handshake done and more than one slot held) stays in `DR_SEND` with the following slot. The transition *last* (handshake done and only one slot held) returns to `DR_IDLE`. Addresses are word addresses: the low two bits select the word within a block.

Top module: `wb_merge_buf`

## Requirements
- R1: After reset the queue is empty: `st_ready` is 1 and `mem_valid` is 0.
- R2: While fewer than four slots are held, a store is accepted in the cycle it is offered, whatever `mem_ready` does.
- R3: A cacheable store whose block matches an unlocked held slot updates that slot and allocates nothing, so no extra memory write appears.
- R4: A fold into a word that was already written replaces its value; the drained data carries the most recent store to each word.
- R5: A store with `(st_addr & IO_MASK) == IO_BASE` always allocates a fresh slot and never folds, even when its block matches a held slot.
- R6: The slot being presented to memory is locked; a store to its block while it waits goes to a new slot and is drained as a separate write.
- R7: `st_ready` is 0 only when all four slots are held and the offered store cannot fold; a store that can fold is accepted while the queue is full.
- R8: Slots drain oldest first, one slot per handshake (`mem_valid` and `mem_ready` both 1), with `mem_addr` equal to the block's first word address (low two bits zero).
- R9: `mem_wmask` bit i is 1 exactly for words written since the slot was allocated; word i occupies `mem_data[32*i +: 32]`.
- R10: While `mem_valid` is 1 and `mem_ready` is 0, `mem_valid`, `mem_addr`, `mem_data` and `mem_wmask` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store offered by the processor |
| st_addr | input | 32 | Store word address |
| st_data | input | 32 | Store data word |
| st_ready | output | 1 | Store accepted this cycle when high |
| mem_valid | output | 1 | A block write is presented to memory |
| mem_addr | output | 32 | Block-aligned word address of the write |
| mem_data | output | 128 | Four data words of the block |
| mem_wmask | output | 4 | Per-word write enable |
| mem_ready | input | 1 | Memory takes the presented write |

## Verification
The bench holds memory back so that the oldest slot sits locked. It then aims stores at that block and at a younger block. A design that folds into the locked slot would lose a write or change data under a pending handshake. A design that never folds would produce extra memory writes. Repeated I/O stores to one block are checked to come out as separate writes, which catches a missing I/O exclusion. With the queue full, a store to a new block must stall while a store to a held block must still pass. This exposes a design that stalls on occupancy alone, and one that overruns its slots.

// File: rtl/wb_pkg.sv
package wb_pkg;
    typedef enum logic [0:0] {
        DR_IDLE = 1'b0,
        DR_SEND = 1'b1
    } drain_state_e;
endpackage

// File: rtl/wb_blk_match.sv
module wb_blk_match #(
    parameter int N_ENT = 4,
    parameter int BLK_W = 30,
    parameter int IDX_W = 2
) (
    input  logic [BLK_W-1:0]            req_blk,
    input  logic                        req_io,
    input  logic [N_ENT-1:0]            ent_vld,
    input  logic [N_ENT-1:0]            ent_io,
    input  logic [N_ENT-1:0]            lock_vec,
    input  logic [N_ENT-1:0][BLK_W-1:0] ent_blk,
    output logic                        hit,
    output logic [IDX_W-1:0]            hit_idx
);
    logic [N_ENT-1:0] cand;

    // a slot is a fold target only when held, cacheable, unlocked and same block
    for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
        assign cand[g] = ent_vld[g] && !ent_io[g] && !lock_vec[g]
                         && (ent_blk[g] == req_blk);
    end

    always_comb begin
        hit     = !req_io && (|cand);
        hit_idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (cand[i]) hit_idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/wb_drain_fsm.sv
module wb_drain_fsm
    import wb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic have_data,
    input  logic more_data,
    input  logic mem_ready,
    output logic busy,
    output logic pop
);
    drain_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DR_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DR_IDLE: if (have_data) state_d = DR_SEND;
            DR_SEND: if (mem_ready) state_d = more_data ? DR_SEND : DR_IDLE;
            default: state_d = DR_IDLE;
        endcase
    end

    always_comb begin
        busy = (state_q == DR_SEND);
        pop  = busy && mem_ready;
    end
endmodule

// File: rtl/wb_merge_buf.sv
module wb_merge_buf #(
    parameter int                N_ENT   = 4,
    parameter int                N_WORDS = 4,
    parameter int                ADDR_W  = 32,
    parameter int                DATA_W  = 32,
    parameter logic [ADDR_W-1:0] IO_BASE = 32'hF000_0000,
    parameter logic [ADDR_W-1:0] IO_MASK = 32'hF000_0000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      st_valid,
    input  logic [ADDR_W-1:0]         st_addr,
    input  logic [DATA_W-1:0]         st_data,
    output logic                      st_ready,
    output logic                      mem_valid,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic [N_WORDS*DATA_W-1:0] mem_data,
    output logic [N_WORDS-1:0]        mem_wmask,
    input  logic                      mem_ready
);
    localparam int OFF_W = $clog2(N_WORDS);
    localparam int BLK_W = ADDR_W - OFF_W;
    localparam int IDX_W = $clog2(N_ENT);
    localparam int CNT_W = $clog2(N_ENT + 1);

    logic [N_ENT-1:0]                           ent_vld;
    logic [N_ENT-1:0]                           ent_io;
    logic [N_ENT-1:0][BLK_W-1:0]                ent_blk;
    logic [N_ENT-1:0][N_WORDS-1:0]              ent_mask;
    logic [N_ENT-1:0][N_WORDS-1:0][DATA_W-1:0]  ent_data;

    logic [IDX_W-1:0] head_q, tail_q;
    logic [CNT_W-1:0] cnt_q;

    logic [BLK_W-1:0] st_blk;
    logic [OFF_W-1:0] st_word;
    logic             st_io;
    logic [N_ENT-1:0] lock_vec;
    logic             match_hit;
    logic [IDX_W-1:0] match_idx;
    logic             busy, pop, full, do_merge, do_alloc;

    function automatic logic [IDX_W-1:0] ptr_next(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(N_ENT - 1)) ? '0 : p + 1'b1;
    endfunction

    assign st_blk  = st_addr[ADDR_W-1:OFF_W];
    assign st_word = st_addr[OFF_W-1:0];
    assign st_io   = ((st_addr & IO_MASK) == IO_BASE);

    always_comb begin
        lock_vec = '0;
        if (busy) lock_vec[head_q] = 1'b1;
    end

    wb_blk_match #(.N_ENT(N_ENT), .BLK_W(BLK_W), .IDX_W(IDX_W)) u_match (
        .req_blk  (st_blk),
        .req_io   (st_io),
        .ent_vld  (ent_vld),
        .ent_io   (ent_io),
        .lock_vec (lock_vec),
        .ent_blk  (ent_blk),
        .hit      (match_hit),
        .hit_idx  (match_idx)
    );

    wb_drain_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .have_data (cnt_q != '0),
        .more_data (cnt_q > CNT_W'(1)),
        .mem_ready (mem_ready),
        .busy      (busy),
        .pop       (pop)
    );

    assign full     = (cnt_q == CNT_W'(N_ENT));
    assign st_ready = match_hit || !full;
    assign do_merge = st_valid && st_ready && match_hit;
    assign do_alloc = st_valid && st_ready && !match_hit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_vld <= '0;
            head_q  <= '0;
            tail_q  <= '0;
            cnt_q   <= '0;
        end else begin
            if (do_merge) begin
                ent_data[match_idx][st_word] <= st_data;
                ent_mask[match_idx][st_word] <= 1'b1;
            end
            if (do_alloc) begin
                ent_vld[tail_q]           <= 1'b1;
                ent_io[tail_q]            <= st_io;
                ent_blk[tail_q]           <= st_blk;
                ent_mask[tail_q]          <= N_WORDS'(1) << st_word;
                ent_data[tail_q]          <= '0;
                ent_data[tail_q][st_word] <= st_data;
                tail_q                    <= ptr_next(tail_q);
            end
            if (pop) begin
                ent_vld[head_q] <= 1'b0;
                head_q          <= ptr_next(head_q);
            end
            cnt_q <= cnt_q + CNT_W'(do_alloc) - CNT_W'(pop);
        end
    end

    always_comb begin
        mem_valid = busy;
        mem_addr  = {ent_blk[head_q], {OFF_W{1'b0}}};
        mem_data  = ent_data[head_q];
        mem_wmask = ent_mask[head_q];
    end
endmodule

// File: rtl/wb_merge_buf_chk.sv
module wb_merge_buf_chk #(
    parameter int N_ENT   = 4,
    parameter int N_WORDS = 4,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         st_valid,
    input logic                         st_ready,
    input logic                         st_io,
    input logic                         hit,
    input logic [$clog2(N_ENT+1)-1:0]   cnt,
    input logic                         mem_valid,
    input logic                         mem_ready,
    input logic [ADDR_W-1:0]            mem_addr,
    input logic [N_WORDS*DATA_W-1:0]    mem_data,
    input logic [N_WORDS-1:0]           mem_wmask
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= N_ENT); // R7
    AST_STALL_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_ready) |-> (cnt == N_ENT)); // R7
    AST_FOLD_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_ready && hit && !(mem_valid && mem_ready)) |=> (cnt == $past(cnt))); // R3
    AST_IO_NEW_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_ready && st_io && !(mem_valid && mem_ready)) |=> (cnt == $past(cnt) + 1'b1)); // R5
    AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                       && $stable(mem_data) && $stable(mem_wmask))); // R10
    AST_MASK_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_wmask != '0)); // R9
endmodule

bind wb_merge_buf wb_merge_buf_chk #(
    .N_ENT(N_ENT), .N_WORDS(N_WORDS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_io(st_io), .hit(match_hit), .cnt(cnt_q), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_wmask(mem_wmask)
);

// File: tb/wb_merge_buf_tb.sv
module wb_merge_buf_tb;
    localparam int CLK_P = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         st_valid = 1'b0;
    logic [31:0]  st_addr = '0;
    logic [31:0]  st_data = '0;
    logic         st_ready;
    logic         mem_valid;
    logic [31:0]  mem_addr;
    logic [127:0] mem_data;
    logic [3:0]   mem_wmask;
    logic         mem_ready = 1'b0;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [31:0]  tx_addr [64];
    logic [127:0] tx_data [64];
    logic [3:0]   tx_mask [64];
    int tx_cnt = 0;

    always #(CLK_P/2) clk = ~clk;

    wb_merge_buf u_dut (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
        .st_data(st_data), .st_ready(st_ready), .mem_valid(mem_valid),
        .mem_addr(mem_addr), .mem_data(mem_data), .mem_wmask(mem_wmask),
        .mem_ready(mem_ready)
    );

    always @(negedge clk) begin
        if (rst_n && mem_valid && mem_ready && tx_cnt < 64) begin
            tx_addr[tx_cnt] = mem_addr;
            tx_data[tx_cnt] = mem_data;
            tx_mask[tx_cnt] = mem_wmask;
            tx_cnt = tx_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] expand(input logic [3:0] m);
        logic [127:0] r = '0;
        for (int i = 0; i < 4; i++) if (m[i]) r[32*i +: 32] = '1;
        return r;
    endfunction

    task automatic check_tx(input int idx, input logic [31:0] a, input logic [3:0] m,
                            input logic [127:0] d, input string req);
        chk(tx_addr[idx] == a, {req, " addr"}, tx_addr[idx], a);
        chk(tx_mask[idx] == m, {req, " mask"}, tx_mask[idx], m);
        chk((tx_data[idx] & expand(m)) == d, {req, " data"}, tx_data[idx] & expand(m), d);
    endtask

    task automatic do_store(input logic [31:0] a, input logic [31:0] d, output bit rdy0);
        @(posedge clk); #1;
        st_valid = 1'b1; st_addr = a; st_data = d;
        @(negedge clk);
        rdy0 = st_ready;
        while (!st_ready) @(negedge clk);
        @(posedge clk); #1;
        st_valid = 1'b0;
    endtask

    task automatic set_ready(input logic v);
        @(posedge clk); #1;
        mem_ready = v;
    endtask

    task automatic wait_lock();
        @(negedge clk);
        for (int i = 0; i < 20 && !mem_valid; i++) @(negedge clk);
    endtask

    task automatic wait_tx(input int n);
        for (int i = 0; i < 200 && tx_cnt < n; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(st_ready == 1'b1, "R1 st_ready", st_ready, 1);
        chk(mem_valid == 1'b0, "R1 mem_valid", mem_valid, 0);
    endtask

    task automatic t_fold();
        int base = tx_cnt;
        bit r;
        set_ready(1'b0);
        do_store(32'h0000_0100, 32'hA0, r);
        chk(r, "R2 first store", r, 1);
        wait_lock();
        do_store(32'h0000_0201, 32'h11, r);
        chk(r, "R2 store under held memory", r, 1);
        do_store(32'h0000_0203, 32'h33, r);
        do_store(32'h0000_0201, 32'h55, r);
        do_store(32'h0000_0102, 32'h77, r);
        set_ready(1'b1);
        wait_tx(base + 3);
        chk(tx_cnt - base == 3, "R3 write count", tx_cnt - base, 3);
        check_tx(base, 32'h100, 4'b0001, {96'h0, 32'hA0}, "R8 oldest");
        check_tx(base + 1, 32'h200, 4'b1010, {32'h33, 32'h0, 32'h55, 32'h0}, "R4 R9 folded");
        check_tx(base + 2, 32'h100, 4'b0100, {32'h0, 32'h77, 64'h0}, "R6 locked block");
    endtask

    task automatic t_io();
        int base = tx_cnt;
        bit r;
        set_ready(1'b0);
        do_store(32'h0000_0300, 32'hD0, r);
        wait_lock();
        do_store(32'hF000_0040, 32'hE0, r);
        do_store(32'hF000_0041, 32'hE1, r);
        set_ready(1'b1);
        wait_tx(base + 3);
        chk(tx_cnt - base == 3, "R5 write count", tx_cnt - base, 3);
        check_tx(base + 1, 32'hF000_0040, 4'b0001, {96'h0, 32'hE0}, "R5 first io");
        check_tx(base + 2, 32'hF000_0040, 4'b0010, {64'h0, 32'hE1, 32'h0}, "R5 second io");
    endtask

    task automatic t_full();
        int base = tx_cnt;
        bit r;
        logic [31:0]  a0;
        logic [127:0] d0;
        set_ready(1'b0);
        for (int i = 0; i < 4; i++) begin
            do_store(32'h400 + 32'(4 * i), 32'hC0 + 32'(i), r);
            chk(r, "R2 fill", r, 1);
        end
        @(posedge clk); #1;
        st_valid = 1'b1; st_addr = 32'h410; st_data = 32'hBB;
        @(negedge clk);
        chk(st_ready == 1'b0, "R7 stall new block", st_ready, 0);
        a0 = mem_addr; d0 = mem_data;
        @(posedge clk); #1;
        st_addr = 32'h409; st_data = 32'hC9;
        @(negedge clk);
        chk(st_ready == 1'b1, "R7 fold while full", st_ready, 1);
        @(posedge clk); #1;
        st_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(mem_valid && mem_addr == a0 && mem_data == d0, "R10 hold",
            {mem_valid, mem_addr}, {1'b1, a0});
        set_ready(1'b1);
        wait_tx(base + 4);
        chk(tx_cnt - base == 4, "R8 write count", tx_cnt - base, 4);
        check_tx(base, 32'h400, 4'b0001, {96'h0, 32'hC0}, "R8 order 0");
        check_tx(base + 2, 32'h408, 4'b0011, {64'h0, 32'hC9, 32'hC2}, "R7 folded when full");
        check_tx(base + 3, 32'h40C, 4'b0001, {96'h0, 32'hC3}, "R8 order 3");
        chk(mem_valid == 1'b0 && st_ready == 1'b1, "R1 empty again", {mem_valid, st_ready}, 2'b01);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_fold();
        t_io();
        t_full();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule